// File: doc/BRIEF.md
# Transition-Coded Serial Write Encoder

This block turns a stream of bytes into the waveform for a single disk write line. Each byte is sent most significant bit first, one bit per bit cell. A one bit flips the line at the boundary that opens its cell. A zero bit leaves the line alone for the whole cell. An internal timer counts clock-enable ticks to find cell boundaries. A mode pin selects a short cell of `FAST_TICKS` ticks or a long cell of twice that.

Bytes enter through a valid/ready port. The port feeds a one-byte holding buffer that sits in front of the shift register. `in_ready` is high exactly when the holding buffer is empty, so it also serves as the active-low busy flag. A transfer happens on any clock edge where `in_valid` and `in_ready` are both high. When `in_ready` is low, the producer must keep `in_valid` and `in_data` steady until the transfer happens.

At each cell boundary the shifter does one of three things. It sends its next bit, or it pulls the buffered byte and sends that byte's MSB, or it has nothing to send. The third case is a starve, and it raises the active-low underrun flag. Deasserting `wr_en` freezes the line level and the shifter contents, restarts the cell timer and clears the underrun flag.

Top module: `disk_wr_encoder`

## Requirements
- R1: After reset, `wr_line` is 0, `in_ready` is 1 and `underrun_n` is 1.
- R2: Each byte is sent most significant bit first, one bit per cell boundary, with bit 7 at the first boundary after the byte reaches the shifter.
- R3: A one bit toggles `wr_line` at its cell boundary. A zero bit leaves `wr_line` unchanged.
- R4: With `slow_mode` low, a cell boundary occurs on the edge carrying the 14th tick (`FAST_TICKS`) counted from the enable or from the previous boundary. The line does not change on the edge one tick earlier.
- R5: With `slow_mode` high, a cell lasts twice as many ticks (28 by default).
- R6: The cell timer advances only on edges where `tick` is high. `wr_line` never changes on an edge where `tick` is low.
- R7: A byte accepted while `in_ready` is high fills the buffer, and `in_ready` is low from the next cycle on. `in_ready` returns high after the edge of the boundary that moves the byte into the shifter.
- R8: A buffered byte starts at the boundary right after the previous byte's last bit, with no idle cell in between.
- R9: At a boundary where the shifter and the buffer are both empty while `wr_en` is high, `underrun_n` goes low after that edge and `wr_line` stays unchanged. `underrun_n` then stays low while `wr_en` stays high.
- R10: While `wr_en` is low, `wr_line` holds its level and `underrun_n` is high one cycle later. The unsent bits are kept, and the timer restarts from zero when `wr_en` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that the cell timer counts |
| slow_mode | input | 1 | 1 selects the doubled cell length |
| wr_en | input | 1 | Write enable; 0 freezes shifting |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Holding buffer empty (active-low busy flag) |
| in_data | input | DATA_W | Byte to send |
| wr_line | output | 1 | Transition-coded serial write line |
| underrun_n | output | 1 | Active-low underrun flag |

## Verification
Every result in this block appears one register stage after the edge that causes it. The line flips, and the underrun flag falls, right after the edge that carries the final tick of a cell. `in_ready` falls right after the accepting edge and rises right after the boundary that empties the buffer. The underrun flag clears one edge after `wr_en` is sampled low. The bench counts edges from the falling edge where it raises `wr_en`, and it samples on the falling edge after the edge where a change is due. It also samples one edge earlier to confirm that nothing changed early. Tick gating is checked by driving `tick` on alternate edges, which moves the boundary to the 27th edge.

// File: rtl/dwe_pkg.sv
package dwe_pkg;

  // What the shifter does on a given clock edge.
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,  // no cell boundary on this edge
    ACT_SHIFT  = 2'd1,  // send the next bit already in the shifter
    ACT_LOAD   = 2'd2,  // pull the buffered byte and send its MSB
    ACT_STARVE = 2'd3   // boundary with nothing left to send
  } cell_act_e;

endpackage

// File: rtl/dwe_cell_timer.sv
module dwe_cell_timer #(
  parameter int FAST_TICKS = 14,
  parameter int SLOW_TICKS = 28,
  parameter int CNT_W      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic slow,
  output logic cell_end
);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last     = slow ? SLOW_LAST : FAST_LAST;
  // ">=" also covers a switch to the short cell in the middle of a long one.
  assign at_last  = (cnt_q >= last);
  assign cell_end = run && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dwe_hold_buf.sv
module dwe_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              held_valid,
  output logic [DATA_W-1:0] held_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign in_ready   = !full_q;
  assign accept     = in_valid && !full_q;
  assign held_valid = full_q;
  assign held_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dwe_shifter.sv
module dwe_shifter
  import dwe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BITS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cell_end,
  input  logic              held_valid,
  input  logic [DATA_W-1:0] held_data,
  output logic              take,
  output logic              wr_line,
  output logic              underrun_n
);
  localparam logic [BITS_W-1:0] REST = BITS_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [BITS_W-1:0] left_q;
  logic              line_q;
  logic              starved_q;
  cell_act_e         act;

  always_comb begin
    if (!cell_end)            act = ACT_IDLE;
    else if (left_q != '0)    act = ACT_SHIFT;
    else if (held_valid)      act = ACT_LOAD;
    else                      act = ACT_STARVE;
  end

  assign take       = (act == ACT_LOAD);
  assign wr_line    = line_q;
  assign underrun_n = !starved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      left_q    <= '0;
      line_q    <= 1'b0;
      starved_q <= 1'b0;
    end else begin
      case (act)
        ACT_SHIFT: begin
          line_q <= line_q ^ sh_q[DATA_W-1];
          sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
        end
        ACT_LOAD: begin
          line_q <= line_q ^ held_data[DATA_W-1];
          sh_q   <= {held_data[DATA_W-2:0], 1'b0};
          left_q <= REST;
        end
        ACT_STARVE: starved_q <= 1'b1;
        default: ;
      endcase
      if (!run) starved_q <= 1'b0;
    end
  end
endmodule

// File: rtl/disk_wr_encoder.sv
module disk_wr_encoder #(
  parameter int DATA_W     = 8,
  parameter int FAST_TICKS = 14,
  parameter int SLOW_MULT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              slow_mode,
  input  logic              wr_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_line,
  output logic              underrun_n
);
  localparam int SLOW_TICKS = FAST_TICKS * SLOW_MULT;
  localparam int CNT_W      = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1;
  localparam int BITS_W     = $clog2(DATA_W + 1);

  logic              cell_end;
  logic              take;
  logic              held_valid;
  logic [DATA_W-1:0] held_data;

  dwe_cell_timer #(
    .FAST_TICKS(FAST_TICKS),
    .SLOW_TICKS(SLOW_TICKS),
    .CNT_W     (CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wr_en),
    .tick    (tick),
    .slow    (slow_mode),
    .cell_end(cell_end)
  );

  dwe_hold_buf #(
    .DATA_W(DATA_W)
  ) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .take      (take),
    .held_valid(held_valid),
    .held_data (held_data)
  );

  dwe_shifter #(
    .DATA_W(DATA_W),
    .BITS_W(BITS_W)
  ) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (wr_en),
    .cell_end  (cell_end),
    .held_valid(held_valid),
    .held_data (held_data),
    .take      (take),
    .wr_line   (wr_line),
    .underrun_n(underrun_n)
  );
endmodule

// File: rtl/dwe_checker.sv
module dwe_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_en,
  input logic in_valid,
  input logic in_ready,
  input logic wr_line,
  input logic underrun_n
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_line)) else $error("line moved while disabled"); // R10

  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> underrun_n) else $error("underrun kept while disabled"); // R10

  AST_NO_TICK_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wr_line)) else $error("line moved without tick"); // R6

  AST_FILL_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready) else $error("ready after fill"); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !underrun_n) |=> !underrun_n) else $error("underrun dropped"); // R9

  AST_STARVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun_n) |-> $stable(wr_line)) else $error("line moved on starve"); // R9
endmodule

bind disk_wr_encoder dwe_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wr_line   (wr_line),
  .underrun_n(underrun_n)
);

// File: tb/disk_wr_encoder_tb_top.sv
`timescale 1ns/1ps
module disk_wr_encoder_tb_top;
  localparam int FAST = 14;
  localparam int SLOW = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       slow_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       wr_line;
  logic       underrun_n;

  int  total = 0;
  int  bad = 0;
  logic exp_line = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  disk_wr_encoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .slow_mode (slow_mode),
    .wr_en     (wr_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .wr_line   (wr_line),
    .underrun_n(underrun_n)
  );

  task automatic chk(input string req, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Starts and ends at a falling edge; walks bits hi..lo of b.
  task automatic check_bits(input logic [7:0] b, input int hi, input int lo,
                            input int lim, input string tag_hold, input string tag_edge);
    for (int i = hi; i >= lo; i--) begin
      repeat (lim - 1) @(posedge clk);
      @(negedge clk);
      chk(tag_hold, wr_line, exp_line);
      @(posedge clk);
      @(negedge clk);
      exp_line = exp_line ^ b[i];
      chk(tag_edge, wr_line, exp_line);
    end
  endtask

  task automatic t_reset();
    chk("R1 line", wr_line, 1'b0);
    chk("R1 ready", in_ready, 1'b1);
    chk("R1 underrun_n", underrun_n, 1'b1);
  endtask

  task automatic t_fast_byte();
    send_byte(8'hA5);
    chk("R7 ready low after fill", in_ready, 1'b0);
    wr_en = 1'b1;
    check_bits(8'hA5, 7, 7, FAST, "R4 no early edge", "R2/R3 first bit");
    chk("R7 ready back after move", in_ready, 1'b1);
    check_bits(8'hA5, 6, 0, FAST, "R4 no early edge", "R2/R3 bits");
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    send_byte(8'h96);
    wr_en = 1'b1;
    fork
      send_byte(8'hFF);
    join_none
    check_bits(8'h96, 7, 0, FAST, "R4 hold", "R2/R3 first byte");
    chk("R7 second byte waiting", in_ready, 1'b0);
    check_bits(8'hFF, 7, 0, FAST, "R8 no gap hold", "R8 second byte");
    chk("R7 buffer drained", in_ready, 1'b1);
    chk("R9 no underrun yet", underrun_n, 1'b1);
    repeat (FAST) @(posedge clk);
    @(negedge clk);
    chk("R9 underrun on starve", underrun_n, 1'b0);
    chk("R9 line quiet on starve", wr_line, exp_line);
    repeat (FAST) @(posedge clk);
    @(negedge clk);
    chk("R9 underrun sticky", underrun_n, 1'b0);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 underrun cleared", underrun_n, 1'b1);
    chk("R10 line held", wr_line, exp_line);
  endtask

  task automatic t_slow();
    slow_mode = 1'b1;
    send_byte(8'h81);
    wr_en = 1'b1;
    check_bits(8'h81, 7, 0, SLOW, "R5 no edge at 27 ticks", "R5 slow bits");
    wr_en = 1'b0;
    slow_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_pause();
    send_byte(8'hC3);
    wr_en = 1'b1;
    check_bits(8'hC3, 7, 5, FAST, "R4 hold", "R2/R3 before pause");
    wr_en = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R10 line frozen", wr_line, exp_line);
    chk("R10 underrun high while off", underrun_n, 1'b1);
    wr_en = 1'b1;
    check_bits(8'hC3, 4, 0, FAST, "R10 timer restart hold", "R10 resumed bits");
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_tick_gate();
    send_byte(8'h80);
    tick  = 1'b1;
    wr_en = 1'b1;
    for (int k = 1; k <= 27; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 26) chk("R6 no edge before 14th tick", wr_line, exp_line);
      if (k == 27) begin
        exp_line = ~exp_line;
        chk("R6 edge on 14th tick", wr_line, exp_line);
      end
      tick = (k % 2 == 0) || (k == 27);
    end
    check_bits(8'h80, 6, 0, FAST, "R6 hold", "R6 rest of byte");
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_byte();
    t_back_to_back();
    t_slow();
    t_pause();
    t_tick_gate();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule